// File: doc/BRIEF.md
# Pixel Clock Program Word Calculator

This block turns a requested pixel clock into the program word that a serially loaded clock synthesizer expects. The request is a frequency in steps of 0.01 MHz. The block first checks the request against a legal window. It then brings low frequencies up into the oscillator band by doubling them, and each doubling also doubles a power-of-two post-divider. Next it derives the rounded feedback count from a fixed reference. Finally it packs the feedback field, a post-divider code and constant stop bits into one word. The result comes out together with a done pulse and an error flag. Serialising the word onto the synthesizer's pins is left to a neighbouring block.

The request side is a valid/ready stream. `req_ready` is high only while the calculator is idle. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. While a calculation runs, `req_ready` stays low, so the source must hold its request, and any value it presents during that time is not taken. The result side is plain: `done` pulses for one cycle, and `prog_word`, `err` and `slot_addr` can be read in that cycle and afterwards.

Top module: `pixclk_word_calc`

## Requirements
- R1: For a request f with 1000 <= f <= 15938, `done` pulses with `err` low. `prog_word` then equals the packed result of R4, R5 and R6, computed from f.
- R2: A request above 15938 is rejected. `done` and `err` are both high in the cycle after acceptance, and no calculation is started.
- R3: A request below 1000 (this includes 0) is rejected in the same way as R2.
- R4: Let g = f and k = 0. While g < 8000, g is doubled and k is incremented, so the post-divider is 2^k and k is at most 3. Bits [10:9] of the word carry 3 - k: divide-by-1 gives 2'b11 and divide-by-8 gives 2'b00.
- R5: Bits [8:0] of the word hold n - 257, where n = (floor(46*g*1000/1432) + 500) / 1000 using integer division. This rounds 46*g/1432 to the nearest integer.
- R6: In every successful word, bits [12:11] are 2'b11 (the stop bits) and bits [15:13] are 0.
- R7: `slot_addr` is always 0.
- R8: A rejected request leaves `prog_word` at its previous value. `err` stays high until the next request is accepted, and it drops in the cycle after that acceptance.
- R9: Every accepted in-range request reaches `done` after the same number of cycles, and that number is at most 80. `done` is high for exactly one cycle per request.
- R10: `req_ready` is low from acceptance of an in-range request until its `done`. A request presented during that time is ignored and does not change the result.
- R11: After reset, `req_ready` is 1 and `done`, `err` and `prog_word` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Calculator idle; a request is taken when this and req_valid are both high |
| req_freq | input | 16 | Requested frequency in 0.01 MHz steps |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last accepted request was out of range |
| prog_word | output | 16 | Packed synthesizer program word |
| slot_addr | output | 5 | Synthesizer register slot for the word, always 0 |

## Verification
The hardest case to reach from the ports is the interplay between a rejected request and an earlier good result. The word must survive the rejection, and `err` must survive idle cycles and a second rejection, then clear at the next good acceptance. The bench first establishes a known word, then sends errors above and below the window, and samples across idle gaps between them. The other hard case is a request presented while the block is busy. The bench keeps `req_valid` high with a different frequency for the whole calculation and confirms the result still matches the original request. A strided sweep across the legal window, plus every doubling boundary, exercises all four post-divider codes and both ends of the feedback field.

// File: rtl/pcw_pkg.sv
package pcw_pkg;

  // Frequencies are in 0.01 MHz steps.
  localparam int unsigned REF_FREQ      = 1432;   // reference, about 14.32 MHz
  localparam int unsigned REF_DIV       = 46;     // reference divider constant
  localparam int unsigned ROUND_SCALE   = 1000;   // fixed-point scale for rounding
  localparam int unsigned ROUND_HALF    = 500;    // half of the scale
  localparam int unsigned FREQ_HI       = 15938;  // highest legal request
  localparam int unsigned FREQ_LO       = 1000;   // lowest legal request
  localparam int unsigned VCO_LO        = 8000;   // bottom of the oscillator band
  localparam int unsigned FB_OFFSET     = 257;    // subtracted from the feedback count
  localparam int unsigned MAX_DOUBLINGS = 3;      // 1000 doubled 3 times reaches 8000
  localparam int unsigned FB_BITS       = 9;
  localparam int unsigned CODE_BITS     = 2;
  localparam int unsigned STOP_BITS     = 2;
  localparam logic [STOP_BITS-1:0] STOP_PATTERN = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_NORM,
    ST_MUL,
    ST_D1GO,
    ST_D1,
    ST_D2GO,
    ST_D2
  } calc_state_t;

endpackage

// File: rtl/pcw_range_gate.sv
module pcw_range_gate
  import pcw_pkg::*;
#(
  parameter int unsigned FREQ_W = 16
) (
  input  logic [FREQ_W-1:0] freq,
  output logic              too_high,
  output logic              too_low,
  output logic              in_range
);

  localparam logic [FREQ_W-1:0] LIM_HI = FREQ_W'(FREQ_HI);
  localparam logic [FREQ_W-1:0] LIM_LO = FREQ_W'(FREQ_LO);

  always_comb begin
    too_high = freq > LIM_HI;
    too_low  = freq < LIM_LO;
    in_range = !too_high && !too_low;
  end

endmodule

// File: rtl/pcw_normalizer.sv
module pcw_normalizer
  import pcw_pkg::*;
#(
  parameter int unsigned FREQ_W = 16,
  parameter int unsigned K_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [FREQ_W-1:0] freq_in,
  output logic [FREQ_W-1:0] freq_out,
  output logic [K_W-1:0]    shift_cnt
);

  localparam logic [FREQ_W-1:0] BAND_LO = FREQ_W'(VCO_LO);

  logic [FREQ_W-1:0] f_q;
  logic [K_W-1:0]    k_q;
  logic              below;

  assign below = f_q < BAND_LO;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_q <= '0;
      k_q <= '0;
    end else if (load) begin
      f_q <= freq_in;
      k_q <= '0;
    end else if (step && below) begin
      f_q <= {f_q[FREQ_W-2:0], 1'b0};
      k_q <= k_q + K_W'(1);
    end
  end

  assign freq_out  = f_q;
  assign shift_cnt = k_q;

  // R4: a doubling is only ever needed while fewer than the maximum have occurred
  a_r4_shift_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (step && below) |-> (k_q < K_W'(MAX_DOUBLINGS)));

endmodule

// File: rtl/pcw_restoring_div.sv
module pcw_restoring_div #(
  parameter int unsigned NUM_W = 30,
  parameter int unsigned DEN_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] dividend,
  input  logic [DEN_W-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [NUM_W-1:0] quotient
);

  localparam int unsigned CNT_W = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] den_q;
  logic [DEN_W-1:0] rem_q;
  logic [NUM_W-1:0] quo_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             done_q;

  logic [DEN_W:0]   shifted;
  logic [DEN_W-1:0] diff;
  logic             fits;

  always_comb begin
    shifted = {rem_q, quo_q[NUM_W-1]};
    fits    = shifted >= {1'b0, den_q};
    diff    = shifted[DEN_W-1:0] - den_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      den_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        den_q  <= divisor;
        rem_q  <= '0;
        quo_q  <= dividend;
        cnt_q  <= CNT_W'(NUM_W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q <= fits ? diff : shifted[DEN_W-1:0];
        quo_q <= {quo_q[NUM_W-2:0], fits};
        cnt_q <= cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign quotient = quo_q;

  // R9: completion only follows a running division, so latency is bounded
  a_r9_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy_q));

  // R10: the controller never restarts a division in flight
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q);

  // R5: the running remainder stays below the divisor
  a_r5_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (rem_q < den_q));

endmodule

// File: rtl/pcw_word_pack.sv
module pcw_word_pack
  import pcw_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic [FB_BITS-1:0]   fb_raw,
  input  logic [CODE_BITS-1:0] shift_cnt,
  output logic [WORD_W-1:0]    word
);

  localparam int unsigned PAY_W = STOP_BITS + CODE_BITS + FB_BITS;

  logic [FB_BITS-1:0]   fb_field;
  logic [CODE_BITS-1:0] pd_code;
  logic [PAY_W-1:0]     payload;

  always_comb begin
    fb_field = fb_raw - FB_BITS'(FB_OFFSET);
    pd_code  = CODE_BITS'(MAX_DOUBLINGS) - shift_cnt;
    payload  = {STOP_PATTERN, pd_code, fb_field};
  end

  generate
    if (WORD_W > PAY_W) begin : g_pad
      assign word = {{(WORD_W-PAY_W){1'b0}}, payload};
    end else begin : g_exact
      assign word = payload[WORD_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/pixclk_word_calc.sv
module pixclk_word_calc
  import pcw_pkg::*;
#(
  parameter int unsigned FREQ_W = 16,
  parameter int unsigned NUM_W  = 30,
  parameter int unsigned DEN_W  = 11,
  parameter int unsigned WORD_W = 16,
  parameter int unsigned SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [FREQ_W-1:0] req_freq,
  output logic              done,
  output logic              err,
  output logic [WORD_W-1:0] prog_word,
  output logic [SLOT_W-1:0] slot_addr
);

  localparam int unsigned STEP_W  = $clog2(MAX_DOUBLINGS + 1);
  localparam int unsigned FB_TOP  = FB_OFFSET + (1 << FB_BITS) - 1;
  localparam int unsigned STOP_LO = FB_BITS + CODE_BITS;

  calc_state_t state_q;
  logic [STEP_W-1:0]    step_q;
  logic [NUM_W-1:0]     prod_q;
  logic [NUM_W-1:0]     q1_q;
  logic [WORD_W-1:0]    word_q;
  logic                 done_q;
  logic                 err_q;

  logic                 accept;
  logic                 too_high, too_low, in_range;
  logic [FREQ_W-1:0]    f_norm;
  logic [CODE_BITS-1:0] k_norm;
  logic                 div_start, div_busy, div_done;
  logic [NUM_W-1:0]     div_dividend, div_quot;
  logic [DEN_W-1:0]     div_divisor;
  logic [WORD_W-1:0]    packed_word;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  pcw_range_gate #(.FREQ_W(FREQ_W)) u_gate (
    .freq     (req_freq),
    .too_high (too_high),
    .too_low  (too_low),
    .in_range (in_range)
  );

  pcw_normalizer #(.FREQ_W(FREQ_W), .K_W(CODE_BITS)) u_norm (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept && in_range),
    .step      (state_q == ST_NORM),
    .freq_in   (req_freq),
    .freq_out  (f_norm),
    .shift_cnt (k_norm)
  );

  always_comb begin
    div_start    = (state_q == ST_D1GO) || (state_q == ST_D2GO);
    div_dividend = (state_q == ST_D2GO) ? (q1_q + NUM_W'(ROUND_HALF)) : prod_q;
    div_divisor  = (state_q == ST_D2GO) ? DEN_W'(ROUND_SCALE) : DEN_W'(REF_FREQ);
  end

  pcw_restoring_div #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (div_start),
    .dividend (div_dividend),
    .divisor  (div_divisor),
    .busy     (div_busy),
    .done     (div_done),
    .quotient (div_quot)
  );

  pcw_word_pack #(.WORD_W(WORD_W)) u_pack (
    .fb_raw    (div_quot[FB_BITS-1:0]),
    .shift_cnt (k_norm),
    .word      (packed_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      prod_q  <= '0;
      q1_q    <= '0;
      word_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            err_q <= !in_range;
            if (in_range) begin
              state_q <= ST_NORM;
              step_q  <= '0;
            end else begin
              done_q <= 1'b1;
            end
          end
        end
        ST_NORM: begin
          step_q <= step_q + STEP_W'(1);
          if (step_q == STEP_W'(MAX_DOUBLINGS - 1)) state_q <= ST_MUL;
        end
        ST_MUL: begin
          prod_q  <= NUM_W'(f_norm) * NUM_W'(REF_DIV * ROUND_SCALE);
          state_q <= ST_D1GO;
        end
        ST_D1GO: state_q <= ST_D1;
        ST_D1: begin
          if (div_done) begin
            q1_q    <= div_quot;
            state_q <= ST_D2GO;
          end
        end
        ST_D2GO: state_q <= ST_D2;
        ST_D2: begin
          if (div_done) begin
            word_q  <= packed_word;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done      = done_q;
  assign err       = err_q;
  assign prog_word = word_q;
  assign slot_addr = '0;

  // R2: requests above the window finish at once with the error flag
  a_r2_reject_high: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && too_high) |=> (done && err && req_ready));

  // R3: requests below the window finish at once with the error flag
  a_r3_reject_low: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && too_low) |=> (done && err && req_ready));

  // R4: normalisation has reached the oscillator band before the multiply
  a_r4_band_reached: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_MUL) |-> (f_norm >= FREQ_W'(VCO_LO)));

  // R5: the rounded feedback count fits the field after the offset
  a_r5_fb_window: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_D2 && div_done) |->
      (div_quot >= NUM_W'(FB_OFFSET) && div_quot <= NUM_W'(FB_TOP)));

  // R6: a successful word carries the stop bits
  a_r6_stop_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (prog_word[STOP_LO +: STOP_BITS] == STOP_PATTERN));

  // R8: while flagged in error and idle, the word does not move
  a_r8_word_held: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !accept) |=> $stable(prog_word));

  // R10: the divider is never running while a new request can be taken
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !div_busy);

endmodule

// File: tb/test_pixclk_word_calc.sv
module test_pixclk_word_calc;

  localparam int CLK_PERIOD = 10;
  localparam int LAT_BOUND  = 80;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_freq = '0;
  logic        done;
  logic        err;
  logic [15:0] prog_word;
  logic [4:0]  slot_addr;

  int checks = 0;
  int errors = 0;
  int ref_lat = -1;

  always #(CLK_PERIOD/2) clk = ~clk;

  pixclk_word_calc i_pixclk_word_calc (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_freq  (req_freq),
    .done      (done),
    .err       (err),
    .prog_word (prog_word),
    .slot_addr (slot_addr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // Expected word from R4, R5, R6
  function automatic logic [15:0] exp_word(input int f);
    longint g = f;
    int k = 0;
    longint q1, n;
    logic [8:0] fb;
    logic [1:0] code;
    while (g < 8000) begin
      g = g * 2;
      k++;
    end
    q1   = (46 * g * 1000) / 1432;
    n    = (q1 + 500) / 1000;
    fb   = 9'(n - 257);
    code = 2'(3 - k);
    return {3'b000, 2'b11, code, fb};
  endfunction

  // Issue one request; poke keeps a different request on the bus while busy (R10)
  task automatic do_req(input int f, input bit poke);
    int lat;
    bit bad = (f > 15938) || (f < 1000);
    logic [15:0] prev_word = prog_word;
    @(negedge clk);
    chk("R10_ready_idle", {31'b0, req_ready}, 32'd1);
    req_valid = 1'b1;
    req_freq  = 16'(f);
    @(negedge clk);
    lat = 1;
    if (poke && !bad) begin
      req_freq = 16'(f) ^ 16'h0155;
    end else begin
      req_valid = 1'b0;
    end
    if (!bad) begin
      chk("R10_ready_busy", {31'b0, req_ready}, 32'd0);
      chk("R8_err_cleared", {31'b0, err}, 32'd0);
    end
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    req_valid = 1'b0;
    if (bad) begin
      chk(f > 15938 ? "R2_latency" : "R3_latency", lat, 32'd1);
      chk(f > 15938 ? "R2_err" : "R3_err", {31'b0, err}, 32'd1);
      chk("R8_word_held", prog_word, prev_word);
    end else begin
      if (ref_lat < 0) begin
        ref_lat = lat;
        chk("R9_lat_bound", {31'b0, lat <= LAT_BOUND}, 32'd1);
      end
      chk("R9_lat_const", lat, ref_lat);
      chk("R1_err_low", {31'b0, err}, 32'd0);
      chk("R1_R4_R5_R6_word", prog_word, exp_word(f));
    end
    chk("R7_slot", slot_addr, 32'd0);
    @(negedge clk);
    chk("R9_done_pulse", {31'b0, done}, 32'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11_ready", {31'b0, req_ready}, 32'd1);
    chk("R11_done", {31'b0, done}, 32'd0);
    chk("R11_err", {31'b0, err}, 32'd0);
    chk("R11_word", prog_word, 32'd0);
    chk("R7_slot_reset", slot_addr, 32'd0);

    // Doubling boundaries and window edges (R1, R4, R5)
    do_req(1000, 1'b0);
    do_req(1001, 1'b0);
    do_req(1999, 1'b0);
    do_req(2000, 1'b0);
    do_req(3999, 1'b0);
    do_req(4000, 1'b0);
    do_req(7999, 1'b0);
    do_req(8000, 1'b0);
    do_req(15937, 1'b0);
    do_req(15938, 1'b0);
    // Explicit code checks for each post-divider (R4)
    chk("R4_code_div1", {30'b0, prog_word[10:9]}, 32'd3);
    do_req(1500, 1'b0);
    chk("R4_code_div8", {30'b0, prog_word[10:9]}, 32'd0);

    // Rejections (R2, R3) and error persistence (R8)
    do_req(5000, 1'b0);
    held = prog_word;
    do_req(15939, 1'b0);
    repeat (3) @(negedge clk);
    chk("R8_err_persists", {31'b0, err}, 32'd1);
    chk("R8_word_idle", prog_word, held);
    do_req(999, 1'b0);
    do_req(0, 1'b0);
    do_req(65535, 1'b0);
    chk("R8_word_after_errs", prog_word, held);
    do_req(12000, 1'b0);

    // Requests held during busy are ignored (R10)
    do_req(3333, 1'b1);
    do_req(9001, 1'b1);

    // Strided sweep over the legal window (R1)
    for (int f = 1003; f <= 15938; f += 17) begin
      do_req(f, 1'b0);
    end
    // Sweep of rejected values (R2, R3)
    for (int f = 0; f < 1000; f += 97) begin
      do_req(f, 1'b0);
    end
    for (int f = 15939; f < 65536; f += 4099) begin
      do_req(f, 1'b0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule